// File: doc/BRIEF.md
# Quarter-Wave Phase-Truncated Sine Synthesizer

This block is a direct digital synthesizer. It produces one signed sine sample on every clock cycle, so the sample rate equals the clock rate. It can also produce a cosine sample in the same cycle. A 32-bit phase accumulator advances by a frequency tuning word on each cycle and wraps modulo 2^32. Only the top `PHASE_W` bits of the accumulator are kept. The two highest kept bits pick the quadrant, and the rest address a table in synchronous block memory. That table stores only the first quarter of the wave. The quadrant bits reverse the read order in the odd quadrants and negate the result in the second half of the cycle. Together these rebuild the full period from one quarter.

The tuning word is `round(f_out / f_clk * 2^32)`. For example, 10.457 MHz and 80.957 MHz at a 245.76 MHz clock are each set by loading one word. The truncation width and output width set the spur level. Spurs fall by about 6 dB per kept bit. `PHASE_W = 12` with `SAMPLE_W = 12` gives a 70 dBc configuration. `PHASE_W = 16` with `SAMPLE_W = 16` gives a 94 dBc configuration. A small state machine has three states:

- `ST_FLUSH` is the reset state. The first clock edge after reset moves it to `ST_PRIME` (transition *flush done*).
- `ST_PRIME` moves to `ST_RUN` on the next edge (transition *pipeline primed*).
- `ST_RUN` holds until reset (transition *stay running*).

Any reset returns the machine to `ST_FLUSH`. The valid strobe is registered from this machine.

Top module: `dds_quarter_synth`

## Requirements
- R1: While reset is sampled high, `sample_valid` is 0 and both `sample_sin` and `sample_cos` are 0 after the next clock edge.
- R2: After reset is released, `sample_valid` stays 0 after the first rising edge. It is 1 after the second rising edge and stays 1 until reset.
- R3: Reset clears the accumulator phase to 0 and the tuning word to 0. The first valid sample after reset, and every sample until a load, is the phase-0 sample.
- R4: The accumulator adds the held tuning word on every rising edge, modulo 2^32. If the accumulator holds a_k, then sample S(a_k) is presented two clock edges later, and consecutive valid samples follow consecutive accumulator values.
- R5: A tuning word on `ftw_in` is captured on a rising edge where `ftw_load` is 1. The accumulation at that edge still uses the old word, and the new word applies from the following edge.
- R6: The quadrant is accumulator bits [31:30]. When bit 30 is 1 (quadrants 1 and 3), the table index (the kept bits below the quadrant) is bit-inverted, so the quarter is read backwards.
- R7: When accumulator bit 31 is 1 (the second half-cycle), the table magnitude is negated. Otherwise it is output unchanged.
- R8: Table entry k holds round((2^(SAMPLE_W-1) - 1) * sin(2*pi*(k + 0.5) / 2^PHASE_W)), so the phase-0 sample equals entry 0.
- R9: With `HAS_COS` set, `sample_cos` equals the sine sample for phase + 2^30, aligned with `sample_sin`. With `HAS_COS` cleared, it is 0.
- R10: While `ftw_load` is 0, changes on `ftw_in` have no effect on the output sample stream.
- R11: The tuning words round(10.457e6 / 245.76e6 * 2^32) and round(80.957e6 / 245.76e6 * 2^32) produce the sample streams that R4 through R8 predict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ftw_load | input | 1 | Capture strobe for the tuning word |
| ftw_in | input | ACC_W | Frequency tuning word |
| sample_sin | output | SAMPLE_W | Signed sine sample, registered |
| sample_cos | output | SAMPLE_W | Signed cosine sample, registered (0 when disabled) |
| sample_valid | output | 1 | High when the samples carry a pipeline-filled result |

## Verification
On every cycle, the embedded assertions check four things:

- the accumulator steps by the word held one cycle earlier;
- the tuning-word register captures on a load and holds otherwise;
- the output sign follows the delayed quadrant MSB for every nonzero magnitude;
- the valid strobe never drops outside reset.

Only the bench scenarios can show the rest. These are the table values themselves, the backward read in odd quadrants, the exact two-edge latency from accumulator to output, the quarter-cycle offset of the cosine, and the behaviour at the two target frequencies. The bench also covers a wrapping word near 2^32 and a restart from phase zero after a mid-run reset.

// File: rtl/dds_pkg.sv
package dds_pkg;

    // Pipeline fill sequencing for the valid strobe
    typedef enum logic [1:0] {
        ST_FLUSH = 2'd0,
        ST_PRIME = 2'd1,
        ST_RUN   = 2'd2
    } dds_state_e;

    // Shared constant used when the quarter table is computed
    localparam real DDS_TWO_PI = 6.283185307179586;

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int ACC_W   = 32,
    parameter int PHASE_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [ACC_W-1:0]   ftw_in,
    output logic [PHASE_W-1:0] phase_top
);

    logic [ACC_W-1:0] ftw_q;
    logic [ACC_W-1:0] acc_q;

    // Tuning word register: captured only on a load strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            ftw_q <= '0;
        end else if (load) begin
            ftw_q <= ftw_in;
        end
    end

    // Phase accumulator, wraps modulo 2^ACC_W
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_q + ftw_q;
        end
    end

    // Phase truncation: keep only the upper bits
    assign phase_top = acc_q[ACC_W-1 -: PHASE_W];

    // R4: each step adds the word held on the previous cycle
    a_r4_acc_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> acc_q == $past(acc_q) + $past(ftw_q));

    // R5: a load captures the presented word
    a_r5_ftw_take: assert property (@(posedge clk) disable iff (rst)
        load |=> ftw_q == $past(ftw_in));

    // R10: without a load the word is held
    a_r10_ftw_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(ftw_q));

endmodule

// File: rtl/dds_quarter_rom.sv
module dds_quarter_rom #(
    parameter int ADDR_W = 10,
    parameter int MAG_W  = 11,
    parameter int PORTS  = 2
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] rd_addr [PORTS],
    output logic [MAG_W-1:0]  rd_data [PORTS]
);
    import dds_pkg::*;

    localparam int  DEPTH    = 1 << ADDR_W;
    localparam int  FULL_PTS = DEPTH * 4;
    localparam real AMP      = real'((1 << MAG_W) - 1);

    logic [MAG_W-1:0] mem [DEPTH];

    // R8: quarter table with half-step offset, computed at start-up
    initial begin
        for (int k = 0; k < DEPTH; k++) begin
            mem[k] = MAG_W'($rtoi(AMP * $sin(DDS_TWO_PI * (real'(k) + 0.5)
                                   / real'(FULL_PTS)) + 0.5));
        end
    end

    // One synchronous read port per channel
    genvar p;
    generate
        for (p = 0; p < PORTS; p++) begin : g_port
            always_ff @(posedge clk) begin
                rd_data[p] <= mem[rd_addr[p]];
            end
        end
    endgenerate

endmodule

// File: rtl/dds_fold.sv
module dds_fold #(
    parameter int PHASE_W  = 12,
    parameter int SAMPLE_W = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [PHASE_W-1:0]         phase_in,
    output logic [PHASE_W-3:0]         rom_addr,
    input  logic [SAMPLE_W-2:0]        rom_mag,
    output logic signed [SAMPLE_W-1:0] sample_out
);

    localparam int ADDR_W = PHASE_W - 2;

    logic [1:0]        quad;
    logic [ADDR_W-1:0] idx;
    logic              neg_q;
    logic signed [SAMPLE_W-1:0] mag_s;

    assign quad = phase_in[PHASE_W-1 -: 2];
    assign idx  = phase_in[ADDR_W-1:0];

    // R6: odd quadrants read the quarter backwards
    assign rom_addr = quad[0] ? ~idx : idx;

    // Sign flag travels alongside the memory read
    always_ff @(posedge clk) begin
        if (rst) begin
            neg_q <= 1'b0;
        end else begin
            neg_q <= quad[1];
        end
    end

    assign mag_s = $signed({1'b0, rom_mag});

    // R7: second half-cycle is negated
    always_ff @(posedge clk) begin
        if (rst) begin
            sample_out <= '0;
        end else if (neg_q) begin
            sample_out <= -mag_s;
        end else begin
            sample_out <= mag_s;
        end
    end

    // R7: negative half yields a negative sample for a nonzero magnitude
    a_r7_negate: assert property (@(posedge clk) disable iff (rst)
        (neg_q && rom_mag != '0) |=> sample_out[SAMPLE_W-1]);

    // R7: positive half never yields a negative sample
    a_r7_positive: assert property (@(posedge clk) disable iff (rst)
        !neg_q |=> !sample_out[SAMPLE_W-1]);

endmodule

// File: rtl/dds_quarter_synth.sv
module dds_quarter_synth
    import dds_pkg::*;
#(
    parameter int ACC_W    = 32,
    parameter int PHASE_W  = 12,
    parameter int SAMPLE_W = 12,
    parameter bit HAS_COS  = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ftw_load,
    input  logic [ACC_W-1:0]    ftw_in,
    output logic [SAMPLE_W-1:0] sample_sin,
    output logic [SAMPLE_W-1:0] sample_cos,
    output logic                sample_valid
);

    localparam int ADDR_W = PHASE_W - 2;
    localparam int MAG_W  = SAMPLE_W - 1;
    localparam int NCH    = HAS_COS ? 2 : 1;
    localparam logic [PHASE_W-1:0] QUARTER = PHASE_W'(1) << ADDR_W;

    dds_state_e state_q, state_d;

    logic [PHASE_W-1:0]         phase_top;
    logic [PHASE_W-1:0]         ch_phase  [NCH];
    logic [ADDR_W-1:0]          ch_addr   [NCH];
    logic [MAG_W-1:0]           ch_mag    [NCH];
    logic signed [SAMPLE_W-1:0] ch_sample [NCH];

    // ---------------- control state machine ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLUSH: state_d = ST_PRIME;
            ST_PRIME: state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_FLUSH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FLUSH;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process: valid follows the fill sequence
    always_ff @(posedge clk) begin
        if (rst) begin
            sample_valid <= 1'b0;
        end else begin
            unique case (state_q)
                ST_FLUSH: sample_valid <= 1'b0;
                ST_PRIME: sample_valid <= 1'b1;
                ST_RUN:   sample_valid <= 1'b1;
                default:  sample_valid <= 1'b0;
            endcase
        end
    end

    // ---------------- datapath ----------------
    dds_phase_acc #(
        .ACC_W   (ACC_W),
        .PHASE_W (PHASE_W)
    ) u_acc (
        .clk       (clk),
        .rst       (rst),
        .load      (ftw_load),
        .ftw_in    (ftw_in),
        .phase_top (phase_top)
    );

    assign ch_phase[0] = phase_top;

    generate
        if (HAS_COS) begin : g_cos
            // R9: cosine leads by a quarter cycle
            assign ch_phase[NCH-1] = phase_top + QUARTER;
            assign sample_cos      = ch_sample[NCH-1];
        end else begin : g_nocos
            assign sample_cos = '0;
        end
    endgenerate

    dds_quarter_rom #(
        .ADDR_W (ADDR_W),
        .MAG_W  (MAG_W),
        .PORTS  (NCH)
    ) u_rom (
        .clk     (clk),
        .rd_addr (ch_addr),
        .rd_data (ch_mag)
    );

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            dds_fold #(
                .PHASE_W  (PHASE_W),
                .SAMPLE_W (SAMPLE_W)
            ) u_fold (
                .clk        (clk),
                .rst        (rst),
                .phase_in   (ch_phase[c]),
                .rom_addr   (ch_addr[c]),
                .rom_mag    (ch_mag[c]),
                .sample_out (ch_sample[c])
            );
        end
    endgenerate

    assign sample_sin = ch_sample[0];

    // R2: once valid, stays valid until reset
    a_r2_valid_sticky: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> sample_valid);

    // R2: valid never rises straight out of the flush state
    a_r2_no_early_valid: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FLUSH) |=> !sample_valid);

endmodule

// File: tb/dds_quarter_synth_test.sv
module dds_quarter_synth_test;

    localparam int  ACC_W    = 32;
    localparam int  PHASE_W  = 12;
    localparam int  SAMPLE_W = 12;
    localparam int  M        = 1 << (PHASE_W - 2);
    localparam real AMP      = real'((1 << (SAMPLE_W - 1)) - 1);
    localparam real TWO_PI   = 6.283185307179586;
    localparam real FCLK     = 245.76e6;

    typedef struct {
        logic [31:0] ph;
        bit          first;
    } exp_t;

    logic                clk = 1'b0;
    logic                rst;
    logic                ftw_load;
    logic [ACC_W-1:0]    ftw_in;
    logic [SAMPLE_W-1:0] sample_sin;
    logic [SAMPLE_W-1:0] sample_cos;
    logic                sample_valid;

    int    n_chk = 0;
    int    n_bad = 0;
    string scen  = "init";
    exp_t  q[$];
    logic [31:0] acc_m;
    logic [31:0] ftw_m;
    bit          first_m;

    always #2 clk = ~clk; // 250 MHz

    dds_quarter_synth #(
        .ACC_W    (ACC_W),
        .PHASE_W  (PHASE_W),
        .SAMPLE_W (SAMPLE_W),
        .HAS_COS  (1'b1)
    ) uut (
        .clk          (clk),
        .rst          (rst),
        .ftw_load     (ftw_load),
        .ftw_in       (ftw_in),
        .sample_sin   (sample_sin),
        .sample_cos   (sample_cos),
        .sample_valid (sample_valid)
    );

    // Expected sample for a 32-bit phase (R6, R7, R8)
    function automatic int s_of(logic [31:0] ph);
        int  p;
        int  qd;
        int  i;
        int  m;
        real x;
        p  = int'(ph >> (32 - PHASE_W));
        qd = p >> (PHASE_W - 2);
        i  = p & (M - 1);
        if (qd[0]) i = M - 1 - i;
        x  = AMP * $sin(TWO_PI * (real'(i) + 0.5) / real'(1 << PHASE_W));
        m  = $rtoi(x + 0.5);
        return qd[1] ? -m : m;
    endfunction

    function automatic logic [31:0] word_for(real f);
        return 32'(longint'(f / FCLK * 4294967296.0));
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", req, scen, act, exp);
        end
    endtask

    // Driver-side model: pushes expected phases as the accumulator advances
    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            acc_m   = '0;
            ftw_m   = '0;
            first_m = 1'b1;
        end else begin
            q.push_back('{ph: acc_m, first: first_m});
            first_m = 1'b0;
            acc_m   = acc_m + ftw_m;
            if (ftw_load) ftw_m = ftw_in;
        end
    end

    // Monitor: pops and compares each valid result
    always @(negedge clk) begin
        if (sample_valid) begin
            if (q.size() == 0) begin
                check("R4", 1, 0);
            end else begin
                exp_t  e;
                string tag;
                e = q.pop_front();
                if (e.first)          tag = "R3";
                else if (e.ph[30])    tag = "R6";
                else if (e.ph[31])    tag = "R7";
                else                  tag = "R4";
                check(tag, int'($signed(sample_sin)), s_of(e.ph));
                check("R9", int'($signed(sample_cos)), s_of(e.ph + 32'h4000_0000));
            end
        end
    end

    task automatic load_word(logic [31:0] w);
        @(negedge clk);
        ftw_in   = w;
        ftw_load = 1'b1;
        @(negedge clk);
        ftw_load = 1'b0;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        rst      = 1'b1;
        ftw_load = 1'b0;
        ftw_in   = '0;
        run(5);
        scen = "reset";
        check("R1", int'(sample_valid), 0);
        check("R1", int'(sample_sin), 0);
        check("R1", int'(sample_cos), 0);

        rst = 1'b0;
        @(negedge clk);
        check("R2", int'(sample_valid), 0);
        @(negedge clk);
        check("R2", int'(sample_valid), 1);
        check("R8", int'($signed(sample_sin)),
              $rtoi(AMP * $sin(TWO_PI * 0.5 / real'(1 << PHASE_W)) + 0.5));
        scen = "R3 idle word";
        run(20);

        scen = "R5 quarter step";
        load_word(32'h4000_0000);
        run(40);

        scen = "R11 10.457 MHz";
        load_word(word_for(10.457e6));
        run(3000);

        scen = "R11 80.957 MHz";
        load_word(word_for(80.957e6));
        run(2000);

        scen = "R4 wrap";
        load_word(32'hFFFF_F000);
        run(600);

        scen = "R5 odd step";
        load_word(32'h0123_4567);
        run(300);

        scen = "R10 no load";
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            ftw_in = $urandom();
        end
        run(5);

        scen = "R1 mid reset";
        @(negedge clk);
        rst = 1'b1;
        run(3);
        check("R1", int'(sample_valid), 0);
        check("R1", int'(sample_sin), 0);
        rst = 1'b0;
        scen = "R3 restart";
        @(negedge clk);
        check("R2", int'(sample_valid), 0);
        run(30);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule